// File: doc/BRIEF.md
# Complementary PWM Channel with Polarity

This block is one pulse-width modulation channel. It drives a main output and a complementary output. Each frame lasts a programmable number of divided-clock ticks. The frame splits into two parts. The count part comes first and lasts for the compare length. The remaining part fills the frame up to the period length. A clock-enable input from an external prescaler sets the rate at which the frame position advances. A 16-bit position output shows where the channel is within the current frame.

By default the main output is high in the count part and low in the remaining part. A first-level polarity bit swaps those two levels. The complementary output is the inverse of the main output. Each output then has its own inversion bit. New compare and period values take effect only at a frame boundary, or at once while the channel is disabled.

At the end of every frame the channel sets a sticky done flag. Software clears the flag by pulsing a write-one clear input. A mask input gates the flag onto the interrupt line.

Top module: `pwm_comp_channel`

## Requirements
- R1: While `chan_en` is 1, `frame_pos` rises by one on each clock edge with `tick_en` = 1 and keeps its value when `tick_en` = 0. When a tick arrives at position `max_len`-1 (period length of the latched frame), `frame_pos` returns to 0.
- R2: With `first_low`, `inv_main` and `inv_comp` all 0, `pwm_main` is 1 while `frame_pos` < the latched compare length, and 0 for the rest of the frame.
- R3: Before the inversion bits are applied, `pwm_comp` is the logical inverse of `pwm_main`.
- R4: With `first_low` = 1, the levels swap: the count part is low and the remaining part is high.
- R5: `inv_main` inverts only `pwm_main`, and `inv_comp` inverts only `pwm_comp`. Each acts after the polarity stage.
- R6: The compare and period lengths are latched while the channel is disabled, and on the tick that ends a frame. A change to `cmp_len` or `max_len` during a frame does not alter that frame.
- R7: A compare length of 0 holds the remaining level for the whole frame. A compare length at or above the period length holds the count level for the whole frame.
- R8: While `chan_en` is 0, `frame_pos` is 0 and both outputs show the idle level. The idle level is the remaining-part level after polarity, followed by each output's inversion bit.
- R9: `done_flag` becomes 1 on the clock edge that ends a frame and stays at 1 until an edge with `done_clr` = 1. That edge clears it when it does not also end a frame.
- R10: When a frame ends on the same edge as `done_clr` = 1, `done_flag` is 1 afterwards.
- R11: `done_irq` is 1 exactly when `done_flag` and `done_mask` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Divided-clock tick enable |
| chan_en | input | 1 | Channel enable |
| cmp_len | input | 16 | Count-part length in ticks |
| max_len | input | 16 | Frame period in ticks |
| first_low | input | 1 | Swap count and remaining levels |
| inv_main | input | 1 | Invert main output |
| inv_comp | input | 1 | Invert complementary output |
| done_clr | input | 1 | Write-one clear of the done flag |
| done_mask | input | 1 | Interrupt mask for the done flag |
| pwm_main | output | 1 | Main PWM output |
| pwm_comp | output | 1 | Complementary PWM output |
| frame_pos | output | 16 | Current position within the frame |
| done_flag | output | 1 | Sticky frame-done status |
| done_irq | output | 1 | Masked frame-done interrupt |

## Verification
The bench builds the channel with the default 16-bit counter width. It keeps period lengths between 1 and 10 ticks, so every frame in the vector table can be walked tick by tick. The short periods also expose the edge cases: a compare length of 0, one equal to the period, one above it, and a one-tick frame. Because frames are short, one test can end a frame on the same edge as a clear, and another can change the lengths partway through a frame.

// File: rtl/pwm_comp_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the complementary PWM channel.
// Assumes: consumers pick their own counter width by parameter.
package pwm_comp_pkg;

    // Default counter width of the channel.
    localparam int unsigned PWM_DEF_CNT_W = 16;

    // Output shaping controls, grouped so they travel together.
    typedef struct packed {
        logic first_low;   // swap count/remaining levels
        logic inv_main;    // invert main output
        logic inv_comp;    // invert complementary output
    } pwm_out_ctl_t;

endpackage

// File: rtl/pwm_seg_counter.sv
`timescale 1ns/1ps
// Module: pwm_seg_counter
// Tracks the position inside a frame and keeps the shadow copies of the
// compare and period lengths. The shadows load while the channel is
// disabled and on the tick that closes a frame.
// Assumes: tick_en is a one-cycle enable from an external prescaler.
module pwm_seg_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] cmp_in,
    input  logic [CNT_W-1:0] max_in,
    output logic [CNT_W-1:0] pos_q,
    output logic [CNT_W-1:0] cmp_sh,
    output logic [CNT_W-1:0] max_sh,
    output logic             frame_end
);
    localparam int unsigned EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] pos_inc;
    logic             last_slot;

    // Purpose: detect the final tick slot of the latched frame.
    always_comb begin
        pos_inc   = {1'b0, pos_q} + EXT_W'(1);
        last_slot = (pos_inc >= {1'b0, max_sh});
        frame_end = chan_en && tick_en && last_slot;
    end

    // Purpose: advance the position and reload the shadows at frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            cmp_sh <= '0;
            max_sh <= '0;
        end else if (!chan_en) begin
            pos_q  <= '0;
            cmp_sh <= cmp_in;
            max_sh <= max_in;
        end else if (tick_en) begin
            if (last_slot) begin
                pos_q  <= '0;
                cmp_sh <= cmp_in;
                max_sh <= max_in;
            end else begin
                pos_q  <= pos_inc[CNT_W-1:0];
            end
        end
    end

    // R1: a running channel never sits past the end of its frame.
    a_r1_pos_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && max_sh != '0) |-> (pos_q < max_sh));

    // R8: a disabled channel parks its position at zero.
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (pos_q == '0));

    // R6: shadows hold through a running frame.
    a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !frame_end) |=> ($stable(cmp_sh) && $stable(max_sh)));

endmodule

// File: rtl/pwm_level_shaper.sv
`timescale 1ns/1ps
// Module: pwm_level_shaper
// Turns the frame position into the main and complementary levels:
// count/remaining decision, then polarity swap, then per-output inversion.
// Assumes: pos and cmp come from the same latched frame.
module pwm_level_shaper
    import pwm_comp_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             chan_en,
    input  logic [CNT_W-1:0] pos,
    input  logic [CNT_W-1:0] cmp_len,
    input  pwm_out_ctl_t     ctl,
    output logic             lvl_main,
    output logic             lvl_comp
);
    logic in_count;
    logic base_lvl;

    // Purpose: derive both output levels from position and controls.
    always_comb begin
        in_count = chan_en && (pos < cmp_len);
        base_lvl = in_count ^ ctl.first_low;
        lvl_main = base_lvl ^ ctl.inv_main;
        lvl_comp = ~base_lvl ^ ctl.inv_comp;
    end

    // R3: outputs are complementary once their inversions are removed.
    always_comb begin
        a_r3_complement: assert ((lvl_main ^ ctl.inv_main) != (lvl_comp ^ ctl.inv_comp));
    end

endmodule

// File: rtl/pwm_done_status.sv
`timescale 1ns/1ps
// Module: pwm_done_status
// Sticky frame-done flag with write-one clear. A set event takes
// priority over a clear in the same cycle.
// Assumes: frame_end is a single-cycle pulse.
module pwm_done_status (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic clr,
    input  logic mask,
    output logic flag_q,
    output logic irq
);
    // Purpose: set on frame end, clear on write-one, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (frame_end) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    // Purpose: gate the flag onto the interrupt line.
    always_comb irq = flag_q && mask;

    // R10: a frame end always leaves the flag set.
    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> flag_q);

    // R9: a lone clear drops the flag.
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !frame_end) |=> !flag_q);

endmodule

// File: rtl/pwm_comp_channel.sv
`timescale 1ns/1ps
// Module: pwm_comp_channel (top)
// One PWM channel with a main and a complementary output, first-level
// polarity, separate output inversion and a sticky frame-done flag.
// Assumes: tick_en comes from an external prescaler in the clk domain.
module pwm_comp_channel
    import pwm_comp_pkg::*;
#(
    parameter int unsigned CNT_W = PWM_DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             chan_en,
    input  logic [CNT_W-1:0] cmp_len,
    input  logic [CNT_W-1:0] max_len,
    input  logic             first_low,
    input  logic             inv_main,
    input  logic             inv_comp,
    input  logic             done_clr,
    input  logic             done_mask,
    output logic             pwm_main,
    output logic             pwm_comp,
    output logic [CNT_W-1:0] frame_pos,
    output logic             done_flag,
    output logic             done_irq
);
    logic [CNT_W-1:0] cmp_sh;
    logic [CNT_W-1:0] max_sh;
    logic             frame_end;
    pwm_out_ctl_t     ctl;

    // Purpose: bundle the shaping controls.
    always_comb begin
        ctl.first_low = first_low;
        ctl.inv_main  = inv_main;
        ctl.inv_comp  = inv_comp;
    end

    pwm_seg_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .tick_en   (tick_en),
        .cmp_in    (cmp_len),
        .max_in    (max_len),
        .pos_q     (frame_pos),
        .cmp_sh    (cmp_sh),
        .max_sh    (max_sh),
        .frame_end (frame_end)
    );

    pwm_level_shaper #(.CNT_W(CNT_W)) u_shaper (
        .chan_en  (chan_en),
        .pos      (frame_pos),
        .cmp_len  (cmp_sh),
        .ctl      (ctl),
        .lvl_main (pwm_main),
        .lvl_comp (pwm_comp)
    );

    pwm_done_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .clr       (done_clr),
        .mask      (done_mask),
        .flag_q    (done_flag),
        .irq       (done_irq)
    );

endmodule

// File: tb/test_pwm_comp_channel.sv
`timescale 1ns/1ps
module test_pwm_comp_channel;

    typedef struct packed {
        logic [15:0] cmp;
        logic [15:0] max;
        logic        pol;
        logic        im;
        logic        ic;
        logic [15:0] exp_main;  // high cycles of pwm_main in one frame
        logic [15:0] exp_comp;  // high cycles of pwm_comp in one frame
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'd3, 16'd8, 1'b0, 1'b0, 1'b0, 16'd3, 16'd5},  // R2 default
        '{16'd3, 16'd8, 1'b1, 1'b0, 1'b0, 16'd5, 16'd3},  // R4 polarity
        '{16'd5, 16'd8, 1'b0, 1'b1, 1'b0, 16'd3, 16'd3},  // R5 main inverted
        '{16'd2, 16'd6, 1'b0, 1'b0, 1'b1, 16'd2, 16'd2},  // R5 comp inverted
        '{16'd0, 16'd5, 1'b0, 1'b0, 1'b0, 16'd0, 16'd5},  // R7 cmp zero
        '{16'd9, 16'd5, 1'b0, 1'b0, 1'b0, 16'd5, 16'd0},  // R7 cmp above max
        '{16'd4, 16'd4, 1'b1, 1'b1, 1'b1, 16'd4, 16'd0},  // R7 cmp equal, all ctl
        '{16'd1, 16'd1, 1'b0, 1'b0, 1'b0, 16'd1, 16'd0}   // R1 one-tick frame
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        chan_en = 1'b0;
    logic [15:0] cmp_len = '0;
    logic [15:0] max_len = '0;
    logic        first_low = 1'b0;
    logic        inv_main = 1'b0;
    logic        inv_comp = 1'b0;
    logic        done_clr = 1'b0;
    logic        done_mask = 1'b0;
    logic        pwm_main, pwm_comp, done_flag, done_irq;
    logic [15:0] frame_pos;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pwm_comp_channel i_pwm_comp_channel (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .chan_en(chan_en),
        .cmp_len(cmp_len), .max_len(max_len), .first_low(first_low),
        .inv_main(inv_main), .inv_comp(inv_comp), .done_clr(done_clr),
        .done_mask(done_mask), .pwm_main(pwm_main), .pwm_comp(pwm_comp),
        .frame_pos(frame_pos), .done_flag(done_flag), .done_irq(done_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Disable, load config, clear flag; shadows load on this edge.
    task automatic setup(input int c, input int m, input logic p,
                         input logic a, input logic b);
        @(negedge clk);
        chan_en = 1'b0; cmp_len = 16'(c); max_len = 16'(m);
        first_low = p; inv_main = a; inv_comp = b; done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
    endtask

    // Walk one frame from the current negedge; counts highs, checks position.
    task automatic run_frame(input int m, output int hm, output int hc,
                             output int pos_bad);
        hm = 0; hc = 0; pos_bad = 0;
        for (int k = 0; k < m; k++) begin
            #1;
            if (pwm_main) hm++;
            if (pwm_comp) hc++;
            if (int'(frame_pos) != k) pos_bad++;
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int hm, hc, pb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // Reset / idle state, R8 and R11
        chk("R8 reset main", pwm_main, 0);
        chk("R8 reset comp", pwm_comp, 1);
        chk("R8 reset pos", frame_pos, 0);
        chk("R9 reset flag", done_flag, 0);
        chk("R11 reset irq", done_irq, 0);

        // R8: idle level follows polarity then inversion
        first_low = 1'b1; inv_comp = 1'b1; tick_en = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R8 idle main", pwm_main, 1);
        chk("R8 idle comp", pwm_comp, 1);
        chk("R8 idle pos", frame_pos, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            setup(int'(VECS[v].cmp), int'(VECS[v].max), VECS[v].pol,
                  VECS[v].im, VECS[v].ic);
            chan_en = 1'b1; tick_en = 1'b1;
            run_frame(int'(VECS[v].max), hm, hc, pb);
            chk("R2/R4/R5/R7 main highs", hm, int'(VECS[v].exp_main));
            chk("R3/R5/R7 comp highs", hc, int'(VECS[v].exp_comp));
            chk("R1 position sequence", pb, 0);
            #1;
            chk("R9 flag after frame", done_flag, 1);
            chk("R1 wrap to zero", frame_pos, 0);
        end

        // R1: tick_en low holds position
        setup(2, 6, 1'b0, 1'b0, 1'b0);
        chan_en = 1'b1; tick_en = 1'b0;
        repeat (3) @(negedge clk);
        #1 chk("R1 hold without tick", frame_pos, 0);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        repeat (3) @(negedge clk);
        #1 chk("R1 single tick", frame_pos, 1);

        // R6: mid-frame change waits for the boundary
        setup(2, 6, 1'b0, 1'b0, 1'b0);
        chan_en = 1'b1; tick_en = 1'b1;
        #1;
        hm = pwm_main ? 1 : 0;
        @(negedge clk);
        cmp_len = 16'd5; max_len = 16'd10;
        run_frame(5, hc, pb, pb);
        hm += hc;
        chk("R6 old compare kept", hm, 2);
        #1 chk("R6 old period kept", frame_pos, 0);
        run_frame(10, hm, hc, pb);
        chk("R6 new compare used", hm, 5);
        chk("R6 new period used", pb, 0);

        // R9/R10/R11: clear, collision, mask
        setup(1, 3, 1'b0, 1'b0, 1'b0);
        chan_en = 1'b1; tick_en = 1'b1;
        repeat (3) @(negedge clk);
        #1 chk("R9 set at frame end", done_flag, 1);
        done_mask = 1'b0;
        #1 chk("R11 masked irq", done_irq, 0);
        done_mask = 1'b1;
        #1 chk("R11 unmasked irq", done_irq, 1);
        @(negedge clk);          // pos 1
        @(negedge clk);          // pos 2, next edge ends the frame
        done_clr = 1'b1;
        @(negedge clk);
        #1 chk("R10 event beats clear", done_flag, 1);
        @(negedge clk);          // edge at pos 0: clear alone
        done_clr = 1'b0;
        #1 chk("R9 clear drops flag", done_flag, 0);
        chk("R11 irq follows flag", done_irq, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule